// File: doc/BRIEF.md
# Acquisition trigger arm and status controller

This block merges three trigger sources (a software request carried in a control word, a hardware trigger line and a cascade trigger line from a neighbouring unit) into one single-cycle acquisition trigger. The hardware source is gated by an armed state. That state is set by a rising edge on a control bit or on the cascade arm input, and it is dropped by the trigger it lets through unless automatic rearm is selected. All inputs are already in the local clock domain. The control word is expected to come from a register file outside the block.

The block keeps sticky status flags. There is one for each trigger source, one for the combined trigger and one for freeze requests, and a single rising edge on the clear bit of the control word resets all of them. A wrapping counter records every trigger issued. The software trigger and arm control bits are echoed on cascade outputs so that a downstream unit can follow this one. All outputs are registered and change one clock after the input that causes them.

Top module: `acq_trig_ctrl`

## Requirements
- R1: While rst_ni is low, every output is 0, the hardware trigger is disarmed and the count is 0.
- R2: A rising edge on ctrl_i bit 0 (software trigger) makes trig_o high for exactly one cycle, one clock later. Holding the bit high gives no further trigger.
- R3: A rising edge on casc_trig_i makes a one-cycle trig_o one clock later only while ctrl_i bit 1 (cascade enable) is 1. Otherwise it is ignored.
- R4: A rising edge on hw_trig_i makes a one-cycle trig_o one clock later only while the hardware trigger is armed (status_o bit 3). An edge while disarmed produces no trigger, no status flag and no count.
- R5: A rising edge on ctrl_i bit 3 or on casc_arm_i sets status_o bit 3 one clock later. An accepted hardware trigger clears it, unless ctrl_i bit 2 (auto rearm) is 1 in that cycle or an arm edge arrives in the same cycle.
- R6: status_o bits 0, 1 and 2 latch an accepted software, cascade and hardware trigger, and bit 4 latches any trigger. A rising edge on ctrl_i bit 4 clears all of them, and an event in the same cycle as the clear wins.
- R7: freeze_o is one clock after the expression ctrl_i bit 7 OR (hw_freeze_i AND ctrl_i bit 8). status_o bit 5 latches each such freeze event and is cleared like R6.
- R8: trig_cnt_o increments by one in the same cycle as each trig_o pulse and wraps modulo 2^CNT_W.
- R9: casc_trig_o and casc_arm_o equal ctrl_i bits 0 and 3 delayed by one clock.
- R10: ctrl_i bits 5 and 6 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 9 | Control word |
| hw_trig_i | input | 1 | Hardware trigger line |
| casc_trig_i | input | 1 | Cascade trigger line |
| casc_arm_i | input | 1 | Cascade arm line |
| hw_freeze_i | input | 1 | Hardware freeze request |
| trig_o | output | 1 | Combined trigger pulse |
| freeze_o | output | 1 | Freeze request |
| casc_trig_o | output | 1 | Echo of software trigger bit |
| casc_arm_o | output | 1 | Echo of arm bit |
| status_o | output | 6 | Sticky flags and armed state |
| trig_cnt_o | output | CNT_W | Trigger count |

## Verification
The bench compares every output in every cycle against a reference model written from the requirements. Directed sequences drive the hard cases. A hardware edge while disarmed must be dropped, where a design missing the gate would count it. Without auto rearm only one trigger may pass after an arm, where a wrong design would keep firing. A clear in the same cycle as an event must still record the event, where a wrong design would lose the flag. The counter is narrowed so that it wraps, which exposes a saturating counter. A long random sweep of control-bit toggles and line edges then exercises the interactions between sources.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;
  localparam int CTRL_W = 9;
  // control word fields
  localparam int C_SW      = 0;
  localparam int C_CASC_EN = 1;
  localparam int C_AUTO    = 2;
  localparam int C_ARM     = 3;
  localparam int C_CLR     = 4;
  localparam int C_SW_FRZ  = 7;
  localparam int C_HW_FRZ  = 8;
  // status word fields
  localparam int STAT_W  = 6;
  localparam int S_SW    = 0;
  localparam int S_CASC  = 1;
  localparam int S_HW    = 2;
  localparam int S_ARMED = 3;
  localparam int S_COMB  = 4;
  localparam int S_FRZ   = 5;
  // edge detector lanes
  localparam int E_SW   = 0;
  localparam int E_ARM  = 1;
  localparam int E_CLR  = 2;
  localparam int E_HW   = 3;
  localparam int E_CASC = 4;
  localparam int E_CARM = 5;
  localparam int E_W    = 6;
  // sticky flag lanes
  localparam int F_SW   = 0;
  localparam int F_CASC = 1;
  localparam int F_HW   = 2;
  localparam int F_COMB = 3;
  localparam int F_FRZ  = 4;
  localparam int F_W    = 5;
endpackage

// File: rtl/acq_rise_det.sv
module acq_rise_det #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar k = 0; k < W; k++) begin : g_lane
    assign rise_o[k] = lvl_i[k] & ~prev_q[k];
    AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[k] |=> !rise_o[k]); // R2
  end
endmodule

// File: rtl/acq_hw_arm.sv
module acq_hw_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_req_i,
  input  logic hw_edge_i,
  input  logic auto_rearm_i,
  output logic fire_o,
  output logic armed_o
);
  logic armed_q;

  assign fire_o  = hw_edge_i & armed_q;
  assign armed_o = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b0;
    else if (arm_req_i) armed_q <= 1'b1;
    else if (fire_o)    armed_q <= auto_rearm_i;
  end

  AST_ARM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_req_i |=> armed_o); // R5
  AST_ARM_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !auto_rearm_i && !arm_req_i) |=> !armed_o); // R5
  AST_ARM_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && auto_rearm_i) |=> armed_o); // R5
endmodule

// File: rtl/acq_sticky.sv
module acq_sticky #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;
  assign flag_o = flag_q;

  for (genvar k = 0; k < N; k++) begin : g_flag
    // a set in the clearing cycle wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[k] <= 1'b0;
      else if (set_i[k]) flag_q[k] <= 1'b1;
      else if (clr_i)    flag_q[k] <= 1'b0;
    end
    AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[k] && !clr_i) |=> flag_q[k]); // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i[k]) |=> !flag_q[k]); // R6
  end
endmodule

// File: rtl/acq_trig_cnt.sv
module acq_trig_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
  import acq_trig_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              hw_trig_i,
  input  logic              casc_trig_i,
  input  logic              casc_arm_i,
  input  logic              hw_freeze_i,
  output logic              trig_o,
  output logic              freeze_o,
  output logic              casc_trig_o,
  output logic              casc_arm_o,
  output logic [STAT_W-1:0] status_o,
  output logic [CNT_W-1:0]  trig_cnt_o
);
  logic [E_W-1:0] lvl, rise;
  logic [F_W-1:0] set, flag;
  logic hw_fire, armed, casc_fire, sw_fire, trig_any, frz_evt;

  assign lvl[E_SW]   = ctrl_i[C_SW];
  assign lvl[E_ARM]  = ctrl_i[C_ARM];
  assign lvl[E_CLR]  = ctrl_i[C_CLR];
  assign lvl[E_HW]   = hw_trig_i;
  assign lvl[E_CASC] = casc_trig_i;
  assign lvl[E_CARM] = casc_arm_i;

  acq_rise_det #(.W(E_W)) i_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .rise_o(rise)
  );

  acq_hw_arm i_arm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .arm_req_i(rise[E_ARM] | rise[E_CARM]),
    .hw_edge_i(rise[E_HW]),
    .auto_rearm_i(ctrl_i[C_AUTO]),
    .fire_o(hw_fire), .armed_o(armed)
  );

  assign sw_fire   = rise[E_SW];
  assign casc_fire = rise[E_CASC] & ctrl_i[C_CASC_EN];
  assign trig_any  = sw_fire | casc_fire | hw_fire;
  assign frz_evt   = ctrl_i[C_SW_FRZ] | (hw_freeze_i & ctrl_i[C_HW_FRZ]);

  assign set[F_SW]   = sw_fire;
  assign set[F_CASC] = casc_fire;
  assign set[F_HW]   = hw_fire;
  assign set[F_COMB] = trig_any;
  assign set[F_FRZ]  = frz_evt;

  acq_sticky #(.N(F_W)) i_sticky (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set), .clr_i(rise[E_CLR]), .flag_o(flag)
  );

  acq_trig_cnt #(.W(CNT_W)) i_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(trig_any), .cnt_o(trig_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_o      <= 1'b0;
      freeze_o    <= 1'b0;
      casc_trig_o <= 1'b0;
      casc_arm_o  <= 1'b0;
    end else begin
      trig_o      <= trig_any;
      freeze_o    <= frz_evt;
      casc_trig_o <= ctrl_i[C_SW];
      casc_arm_o  <= ctrl_i[C_ARM];
    end
  end

  assign status_o[S_SW]    = flag[F_SW];
  assign status_o[S_CASC]  = flag[F_CASC];
  assign status_o[S_HW]    = flag[F_HW];
  assign status_o[S_ARMED] = armed;
  assign status_o[S_COMB]  = flag[F_COMB];
  assign status_o[S_FRZ]   = flag[F_FRZ];

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (trig_cnt_o == CNT_W'($past(trig_cnt_o) + 1'b1))); // R8
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_o |-> $stable(trig_cnt_o)); // R8
  AST_COMB_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> status_o[S_COMB]); // R6
  AST_UNARMED_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise[E_HW] && !armed && !sw_fire && !casc_fire) |=> !trig_o); // R4
  AST_SW_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[C_SW_FRZ] |=> (freeze_o && status_o[S_FRZ])); // R7
endmodule

// File: tb/test_acq_trig_ctrl.sv
`timescale 1ns/1ps
module test_acq_trig_ctrl;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [8:0] ctrl = '0;
  logic hw = 0, casc = 0, carm = 0, hfz = 0;
  logic trig, frz, ct, ca;
  logic [5:0] st;
  logic [CW-1:0] cnt;
  int vecs = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  acq_trig_ctrl #(.CNT_W(CW)) i_acq_trig_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .hw_trig_i(hw), .casc_trig_i(casc),
    .casc_arm_i(carm), .hw_freeze_i(hfz), .trig_o(trig), .freeze_o(frz),
    .casc_trig_o(ct), .casc_arm_o(ca), .status_o(st), .trig_cnt_o(cnt)
  );

  // reference model from the requirements
  logic [8:0] m_pc;
  logic m_ph, m_pcs, m_pca, m_armed, m_trig, m_frz, m_ct, m_ca;
  logic [4:0] m_fl; // sw, casc, hw, comb, freeze
  logic [CW-1:0] m_cnt;
  always @(posedge clk or negedge rst_n) begin
    logic sw, arm, clr, hwf, csf, any, fz;
    if (!rst_n) begin
      m_pc <= '0; m_ph <= 0; m_pcs <= 0; m_pca <= 0; m_armed <= 0;
      m_trig <= 0; m_frz <= 0; m_ct <= 0; m_ca <= 0; m_fl <= '0; m_cnt <= '0;
    end else begin
      sw  = ctrl[0] & ~m_pc[0];
      arm = (ctrl[3] & ~m_pc[3]) | (carm & ~m_pca);
      clr = ctrl[4] & ~m_pc[4];
      hwf = hw & ~m_ph & m_armed;
      csf = casc & ~m_pcs & ctrl[1];
      any = sw | csf | hwf;
      fz  = ctrl[7] | (hfz & ctrl[8]);
      m_armed <= arm ? 1'b1 : (hwf ? ctrl[2] : m_armed);
      m_fl[0] <= sw  | (m_fl[0] & ~clr);
      m_fl[1] <= csf | (m_fl[1] & ~clr);
      m_fl[2] <= hwf | (m_fl[2] & ~clr);
      m_fl[3] <= any | (m_fl[3] & ~clr);
      m_fl[4] <= fz  | (m_fl[4] & ~clr);
      m_trig <= any; m_frz <= fz; m_ct <= ctrl[0]; m_ca <= ctrl[3];
      m_cnt <= m_cnt + CW'(any);
      m_pc <= ctrl; m_ph <= hw; m_pcs <= casc; m_pca <= carm;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    vecs++;
    chk("R2 R3 R4 trig_o", trig, m_trig);
    chk("R5 armed", st[3], m_armed);
    chk("R6 flags", {st[4], st[2:0]}, {m_fl[3], m_fl[2:0]});
    chk("R7 freeze_o", frz, m_frz);
    chk("R7 freeze flag", st[5], m_fl[4]);
    chk("R8 count", cnt, m_cnt);
    chk("R9 cascade echo", {ct, ca}, {m_ct, m_ca});
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk); compare();
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vecs++; // R1: reset state
    chk("R1 reset", {trig, frz, ct, ca, st, 4'(cnt)}, 0);
    @(negedge clk) rst_n = 1;
    tick(2);
    // R2: sw trigger held high fires once
    ctrl[0] = 1; tick(1); chk("R2 sw pulse", trig, 1);
    tick(3); chk("R2 held high", trig, 0);
    ctrl[0] = 0; tick(2);
    // R3: cascade gated by enable
    casc = 1; tick(1); chk("R3 disabled", trig, 0);
    casc = 0; ctrl[1] = 1; tick(1);
    casc = 1; tick(1); chk("R3 enabled", trig, 1);
    casc = 0; ctrl[1] = 0; tick(1);
    // R4: hw while disarmed is ignored
    hw = 1; tick(1); chk("R4 disarmed", trig, 0); chk("R4 count held", cnt, 2);
    hw = 0; tick(1);
    // R5: arm via bit 3, single shot without auto rearm
    ctrl[3] = 1; tick(1); chk("R5 armed", st[3], 1);
    ctrl[3] = 0; hw = 1; tick(1); chk("R4 armed fire", trig, 1); chk("R5 disarm", st[3], 0);
    hw = 0; tick(1); hw = 1; tick(1); chk("R5 second dropped", trig, 0);
    hw = 0; carm = 1; tick(1); chk("R5 cascade arm", st[3], 1);
    carm = 0; ctrl[2] = 1;
    for (int i = 0; i < 4; i++) begin
      hw = 1; tick(1); chk("R5 auto rearm", trig, 1);
      hw = 0; tick(1);
    end
    // R6: clear with simultaneous event, then plain clear
    ctrl[4] = 1; ctrl[0] = 1; tick(1); chk("R6 set wins", st[0], 1);
    ctrl[4] = 0; ctrl[0] = 0; tick(1);
    ctrl[4] = 1; tick(1); chk("R6 cleared", {st[4], st[2:0]}, 0);
    ctrl[4] = 0; tick(1);
    // R7: freeze combinations
    for (int v = 0; v < 8; v++) begin
      ctrl[7] = v[0]; ctrl[8] = v[1]; hfz = v[2]; tick(1);
      chk("R7 freeze", frz, v[0] | (v[1] & v[2]));
    end
    ctrl[7] = 0; ctrl[8] = 0; hfz = 0;
    // R10: unused bits toggle without effect
    ctrl[5] = 1; ctrl[6] = 1; tick(3); chk("R10 unused", trig, 0);
    ctrl[5] = 0; ctrl[6] = 0;
    // R8: wrap through counter
    for (int i = 0; i < 20; i++) begin ctrl[0] = 1; tick(1); ctrl[0] = 0; tick(1); end
    // random sweep
    for (int i = 0; i < 6000; i++) begin
      for (int b = 0; b < 9; b++) if ($urandom_range(7) == 0) ctrl[b] = ~ctrl[b];
      if ($urandom_range(3) == 0) hw = ~hw;
      if ($urandom_range(3) == 0) casc = ~casc;
      if ($urandom_range(7) == 0) carm = ~carm;
      if ($urandom_range(3) == 0) hfz = ~hfz;
      tick(1);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule